// File: doc/BRIEF.md
# Descriptor Channel Command Controller

This block takes commands from a host for one serial channel. That channel moves its transmit and receive data through rings of buffer descriptors. The host writes three things in one strobe: a 4-bit opcode, a 4-bit channel field and, implicitly, a busy flag. The controller runs the command and then drops the flag, which tells the host that the command register is free again.

The block holds the transmit and receive descriptor pointers and the run/stop state of the transmitter.

- **Transmit side.** The transmitter starts a frame whenever it is running, idle, and the descriptor under its pointer is marked ready. A transmit FIFO model reports each frame boundary; on that report the pointer advances.
- **Transmit commands.** The host can stop the transmitter at once, or stop it gracefully at the end of the frame now in flight. It can then restart at the same descriptor.
- **Receive side.** The host can force the current receive descriptor closed before its buffer is full. The block reports the byte count, and reception moves on to the next descriptor by itself.

Top module: `chan_cmd_ctrl`

## Requirements
- R1: `cmd_flg_o` is set only by a host write. A write is `cmd_wr_i` high at a clock edge while `cmd_flg_o` is low, and it loads the opcode and the channel field. A write made while `cmd_flg_o` is high has no effect.
- R2: Every command except a graceful stop that is waiting on a frame clears `cmd_flg_o` at the edge after the flag rose. The flag is therefore high for exactly one cycle.
- R3: The opcodes are:
  - 4'h1: stop now
  - 4'h2: graceful stop
  - 4'h3: restart
  - 4'h4: close receive descriptor

  Any other opcode changes no pointer, no run state and no output pulse. Neither does a channel field that differs from CHAN_ID.
- R4: Stop now does all of the following:
  - clears `tx_run_o` at the next edge;
  - drops any frame in flight, so a later `tx_frame_end_i` leaves `txbd_ptr_o` unchanged;
  - pulses `tx_stopped_o` for one cycle.
- R5: A graceful stop issued during a frame keeps `tx_run_o` and `cmd_flg_o` high until `tx_frame_end_i`. At that edge:
  - `txbd_ptr_o` advances;
  - `tx_run_o` and `cmd_flg_o` drop;
  - `tx_stopped_o` pulses for one cycle.

  No new frame starts after it, even if the next descriptor is ready.
- R6: A graceful stop issued with no frame in flight clears `tx_run_o`, pulses `tx_stopped_o` and clears the flag, all at the edge after the flag rose.
- R7: Restart sets `tx_run_o`. The next frame uses the current `txbd_ptr_o`; the pointer does not advance.
- R8: When the transmitter is running and idle, and `txbd_rdy_i[txbd_ptr_o]` is seen set at an edge, `tx_start_o` pulses for one cycle at that edge. While that bit is clear the block waits. It starts with no further command once the bit becomes set.
- R9: `tx_frame_end_i` during a frame advances `txbd_ptr_o`. The pointer wraps from TX_BDS-1 to 0.
- R10: The receive close command does all of the following:
  - pulses `rx_close_o` with the current index;
  - reports a length equal to the bytes accepted into that descriptor, including a byte accepted in the same cycle;
  - advances `rxbd_ptr_o`.

  Later bytes fill the next descriptor with no further command.
- R11: A byte on `rx_byte_i` is accepted only while `rxbd_rdy_i[rxbd_ptr_o]` is set. The BUF_BYTES-th accepted byte closes the descriptor with length BUF_BYTES. A close command aimed at a descriptor that is not ready has no effect.
- R12: `rxbd_ptr_o` wraps from RX_BDS-1 to 0.
- R13: While `rst_ni` is low, `cmd_flg_o`, both pointers and `tx_run_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Host write strobe for the command register |
| cmd_op_i | input | 4 | Command opcode |
| cmd_ch_i | input | 4 | Target channel field |
| cmd_flg_o | output | 1 | Command busy flag |
| txbd_rdy_i | input | TX_BDS | Ready bits of the transmit descriptors |
| tx_frame_end_i | input | 1 | Transmit FIFO reports that the current frame has fully left |
| tx_start_o | output | 1 | One-cycle pulse: a frame starts at `txbd_ptr_o` |
| tx_stopped_o | output | 1 | One-cycle pulse: the transmitter has halted |
| tx_run_o | output | 1 | The transmitter is enabled |
| txbd_ptr_o | output | $clog2(TX_BDS) | Current transmit descriptor |
| rxbd_rdy_i | input | RX_BDS | Ready bits of the receive descriptors |
| rx_byte_i | input | 1 | One received byte written into the current buffer |
| rx_close_o | output | 1 | One-cycle pulse: a receive descriptor is closed; clear its ready bit |
| rx_close_idx_o | output | $clog2(RX_BDS) | Index of the descriptor just closed |
| rx_close_len_o | output | $clog2(BUF_BYTES+1) | Byte count written to the closed descriptor |
| rxbd_ptr_o | output | $clog2(RX_BDS) | Current receive descriptor |

## Verification
The hardest situation to reach is a graceful stop that arrives mid-frame while the next transmit descriptor is already marked ready. Only here does holding the flag across many cycles matter, and only here can a stop that fires too early or too late let a new frame slip out.

The stimulus sets up this case directly. It starts a frame and arms the following descriptor before issuing the graceful stop. It then holds off the frame end for several cycles before pulsing it, and checks that no start follows the halt.

Receive closes are driven with random byte counts and gaps, with unused opcodes mixed in between the bytes. A close coinciding with a byte, a close on a descriptor that is not ready, and the pointer wrap are exercised as directed cases.

// File: rtl/chan_cmd_pkg.sv
`timescale 1ns/1ps
package chan_cmd_pkg;
  localparam int CMD_OP_W = 4;
  localparam int CMD_CH_W = 4;
  localparam logic [CMD_OP_W-1:0] OP_TX_HALT  = 4'h1;
  localparam logic [CMD_OP_W-1:0] OP_TX_GRACE = 4'h2;
  localparam logic [CMD_OP_W-1:0] OP_TX_RESUME = 4'h3;
  localparam logic [CMD_OP_W-1:0] OP_RX_CLOSE = 4'h4;
endpackage

// File: rtl/chan_cmd_reg.sv
`timescale 1ns/1ps
module chan_cmd_reg
  import chan_cmd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [CMD_OP_W-1:0] op_i,
  input  logic [CMD_CH_W-1:0] ch_i,
  input  logic                done_i,
  output logic                flg_o,
  output logic [CMD_OP_W-1:0] op_o,
  output logic [CMD_CH_W-1:0] ch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_o <= 1'b0;
      op_o  <= '0;
      ch_o  <= '0;
    end else if (!flg_o) begin
      if (wr_i) begin
        flg_o <= 1'b1;
        op_o  <= op_i;
        ch_o  <= ch_i;
      end
    end else if (done_i) begin
      flg_o <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_tx_ctrl.sv
`timescale 1ns/1ps
module chan_tx_ctrl #(
  parameter int TX_BDS = 8,
  localparam int PTR_W = (TX_BDS > 1) ? $clog2(TX_BDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              grace_i,
  input  logic              resume_i,
  input  logic              frame_end_i,
  input  logic [TX_BDS-1:0] bd_rdy_i,
  output logic              start_o,
  output logic              stopped_o,
  output logic              run_o,
  output logic              busy_o,
  output logic              grace_done_o,
  output logic [PTR_W-1:0]  ptr_o
);
  logic             end_now;
  logic             start_now;
  logic [PTR_W-1:0] ptr_nxt;

  assign ptr_nxt      = (ptr_o == PTR_W'(TX_BDS - 1)) ? '0 : ptr_o + 1'b1;
  assign end_now      = busy_o && frame_end_i;
  // graceful stop completes when idle or on the frame boundary
  assign grace_done_o = grace_i && (!busy_o || frame_end_i);
  assign start_now    = run_o && !busy_o && bd_rdy_i[ptr_o] && !halt_i && !grace_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o     <= 1'b0;
      busy_o    <= 1'b0;
      ptr_o     <= '0;
      start_o   <= 1'b0;
      stopped_o <= 1'b0;
    end else begin
      start_o   <= start_now;
      stopped_o <= halt_i || grace_done_o;
      if (end_now) ptr_o <= ptr_nxt;
      if (halt_i || end_now) busy_o <= 1'b0;
      else if (start_now)    busy_o <= 1'b1;
      if (halt_i || grace_done_o) run_o <= 1'b0;
      else if (resume_i)          run_o <= 1'b1;
    end
  end
endmodule

// File: rtl/chan_rx_ctrl.sv
`timescale 1ns/1ps
module chan_rx_ctrl #(
  parameter int RX_BDS    = 4,
  parameter int BUF_BYTES = 16,
  localparam int PTR_W = (RX_BDS > 1) ? $clog2(RX_BDS) : 1,
  localparam int LEN_W = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              close_i,
  input  logic              byte_i,
  input  logic [RX_BDS-1:0] bd_rdy_i,
  output logic              close_o,
  output logic [PTR_W-1:0]  close_idx_o,
  output logic [LEN_W-1:0]  close_len_o,
  output logic [PTR_W-1:0]  ptr_o
);
  logic             cur_rdy;
  logic             take;
  logic             full;
  logic             do_close;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_nxt;
  logic [PTR_W-1:0] ptr_nxt;

  assign cur_rdy  = bd_rdy_i[ptr_o];
  assign take     = byte_i && cur_rdy;
  assign cnt_nxt  = cnt_q + LEN_W'(take);
  assign full     = take && (cnt_nxt == LEN_W'(BUF_BYTES));
  assign do_close = cur_rdy && (close_i || full);
  assign ptr_nxt  = (ptr_o == PTR_W'(RX_BDS - 1)) ? '0 : ptr_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      ptr_o       <= '0;
      close_o     <= 1'b0;
      close_idx_o <= '0;
      close_len_o <= '0;
    end else begin
      close_o <= do_close;
      if (do_close) begin
        close_idx_o <= ptr_o;
        close_len_o <= cnt_nxt;
        ptr_o       <= ptr_nxt;
        cnt_q       <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/chan_cmd_ctrl.sv
`timescale 1ns/1ps
module chan_cmd_ctrl
  import chan_cmd_pkg::*;
#(
  parameter int                  TX_BDS    = 8,
  parameter int                  RX_BDS    = 4,
  parameter int                  BUF_BYTES = 16,
  parameter logic [CMD_CH_W-1:0] CHAN_ID   = 4'h2,
  localparam int TXP_W = (TX_BDS > 1) ? $clog2(TX_BDS) : 1,
  localparam int RXP_W = (RX_BDS > 1) ? $clog2(RX_BDS) : 1,
  localparam int LEN_W = $clog2(BUF_BYTES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_wr_i,
  input  logic [CMD_OP_W-1:0] cmd_op_i,
  input  logic [CMD_CH_W-1:0] cmd_ch_i,
  output logic                cmd_flg_o,
  input  logic [TX_BDS-1:0]   txbd_rdy_i,
  input  logic                tx_frame_end_i,
  output logic                tx_start_o,
  output logic                tx_stopped_o,
  output logic                tx_run_o,
  output logic [TXP_W-1:0]    txbd_ptr_o,
  input  logic [RX_BDS-1:0]   rxbd_rdy_i,
  input  logic                rx_byte_i,
  output logic                rx_close_o,
  output logic [RXP_W-1:0]    rx_close_idx_o,
  output logic [LEN_W-1:0]    rx_close_len_o,
  output logic [RXP_W-1:0]    rxbd_ptr_o
);
  logic [CMD_OP_W-1:0] cmd_op_q;
  logic [CMD_CH_W-1:0] cmd_ch_q;
  logic                hit;
  logic                sel_halt;
  logic                sel_grace;
  logic                sel_resume;
  logic                sel_close;
  logic                grace_done;
  logic                cmd_done;
  logic                tx_busy;

  assign hit        = cmd_flg_o && (cmd_ch_q == CHAN_ID);
  assign sel_halt   = hit && (cmd_op_q == OP_TX_HALT);
  assign sel_grace  = hit && (cmd_op_q == OP_TX_GRACE);
  assign sel_resume = hit && (cmd_op_q == OP_TX_RESUME);
  assign sel_close  = hit && (cmd_op_q == OP_RX_CLOSE);
  assign cmd_done   = !sel_grace || grace_done;

  chan_cmd_reg u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cmd_wr_i),
    .op_i   (cmd_op_i),
    .ch_i   (cmd_ch_i),
    .done_i (cmd_done),
    .flg_o  (cmd_flg_o),
    .op_o   (cmd_op_q),
    .ch_o   (cmd_ch_q)
  );

  chan_tx_ctrl #(.TX_BDS(TX_BDS)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_i       (sel_halt),
    .grace_i      (sel_grace),
    .resume_i     (sel_resume),
    .frame_end_i  (tx_frame_end_i),
    .bd_rdy_i     (txbd_rdy_i),
    .start_o      (tx_start_o),
    .stopped_o    (tx_stopped_o),
    .run_o        (tx_run_o),
    .busy_o       (tx_busy),
    .grace_done_o (grace_done),
    .ptr_o        (txbd_ptr_o)
  );

  chan_rx_ctrl #(.RX_BDS(RX_BDS), .BUF_BYTES(BUF_BYTES)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .close_i     (sel_close),
    .byte_i      (rx_byte_i),
    .bd_rdy_i    (rxbd_rdy_i),
    .close_o     (rx_close_o),
    .close_idx_o (rx_close_idx_o),
    .close_len_o (rx_close_len_o),
    .ptr_o       (rxbd_ptr_o)
  );
endmodule

// File: rtl/chan_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module chan_cmd_ctrl_chk
  import chan_cmd_pkg::*;
#(
  parameter int                  TX_BDS  = 8,
  parameter int                  RX_BDS  = 4,
  parameter logic [CMD_CH_W-1:0] CHAN_ID = 4'h2,
  localparam int TXP_W = (TX_BDS > 1) ? $clog2(TX_BDS) : 1,
  localparam int RXP_W = (RX_BDS > 1) ? $clog2(RX_BDS) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_wr_i,
  input logic                cmd_flg_o,
  input logic [CMD_OP_W-1:0] cmd_op_q,
  input logic [CMD_CH_W-1:0] cmd_ch_q,
  input logic                tx_busy,
  input logic                tx_frame_end_i,
  input logic                tx_run_o,
  input logic                tx_start_o,
  input logic                tx_stopped_o,
  input logic [TX_BDS-1:0]   txbd_rdy_i,
  input logic [TXP_W-1:0]    txbd_ptr_o,
  input logic                rx_close_o,
  input logic [RXP_W-1:0]    rx_close_idx_o,
  input logic [RXP_W-1:0]    rxbd_ptr_o
);
  logic grace_sel;
  assign grace_sel = cmd_flg_o && (cmd_op_q == OP_TX_GRACE) && (cmd_ch_q == CHAN_ID);

  // R1
  flg_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_flg_o) |-> $past(cmd_wr_i));

  // R2
  flg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_flg_o && (!grace_sel || !tx_busy)) |=> !cmd_flg_o);

  // R4
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_flg_o && cmd_op_q == OP_TX_HALT && cmd_ch_q == CHAN_ID) |=> (!tx_run_o && tx_stopped_o));

  // R5
  grace_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grace_sel && tx_busy && !tx_frame_end_i) |=> (cmd_flg_o && tx_run_o && !tx_stopped_o));

  // R6
  stopped_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stopped_o |-> (!tx_run_o && !tx_start_o));

  // R8
  start_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> ($past(txbd_rdy_i[txbd_ptr_o]) && tx_run_o));

  // R8
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  // R10
  rx_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_close_o |-> (rxbd_ptr_o != rx_close_idx_o));
endmodule

bind chan_cmd_ctrl chan_cmd_ctrl_chk #(
  .TX_BDS(TX_BDS), .RX_BDS(RX_BDS), .CHAN_ID(CHAN_ID)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_wr_i       (cmd_wr_i),
  .cmd_flg_o      (cmd_flg_o),
  .cmd_op_q       (cmd_op_q),
  .cmd_ch_q       (cmd_ch_q),
  .tx_busy        (tx_busy),
  .tx_frame_end_i (tx_frame_end_i),
  .tx_run_o       (tx_run_o),
  .tx_start_o     (tx_start_o),
  .tx_stopped_o   (tx_stopped_o),
  .txbd_rdy_i     (txbd_rdy_i),
  .txbd_ptr_o     (txbd_ptr_o),
  .rx_close_o     (rx_close_o),
  .rx_close_idx_o (rx_close_idx_o),
  .rxbd_ptr_o     (rxbd_ptr_o)
);

// File: tb/chan_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module chan_cmd_ctrl_bench;
  localparam int TX_BDS = 8;
  localparam int RX_BDS = 4;
  localparam int BUF_BYTES = 16;
  localparam logic [3:0] CH = 4'h2;
  localparam logic [3:0] HALT = 4'h1, GRACE = 4'h2, RESUME = 4'h3, CLOSE = 4'h4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_wr_i = 1'b0;
  logic [3:0] cmd_op_i = '0;
  logic [3:0] cmd_ch_i = '0;
  logic cmd_flg_o;
  logic [TX_BDS-1:0] txbd_rdy_i = '0;
  logic tx_frame_end_i = 1'b0;
  logic tx_start_o, tx_stopped_o, tx_run_o;
  logic [2:0] txbd_ptr_o;
  logic [RX_BDS-1:0] rxbd_rdy_i = '0;
  logic rx_byte_i = 1'b0;
  logic rx_close_o;
  logic [1:0] rx_close_idx_o, rxbd_ptr_o;
  logic [4:0] rx_close_len_o;

  int checks = 0;
  int errors = 0;
  int exp_tp;
  int exp_rp;

  always #2.5 clk_i = ~clk_i;

  chan_cmd_ctrl #(.TX_BDS(TX_BDS), .RX_BDS(RX_BDS), .BUF_BYTES(BUF_BYTES), .CHAN_ID(CH)) u_chan_cmd_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr_i), .cmd_op_i(cmd_op_i), .cmd_ch_i(cmd_ch_i),
    .cmd_flg_o(cmd_flg_o), .txbd_rdy_i(txbd_rdy_i), .tx_frame_end_i(tx_frame_end_i),
    .tx_start_o(tx_start_o), .tx_stopped_o(tx_stopped_o), .tx_run_o(tx_run_o), .txbd_ptr_o(txbd_ptr_o),
    .rxbd_rdy_i(rxbd_rdy_i), .rx_byte_i(rx_byte_i), .rx_close_o(rx_close_o),
    .rx_close_idx_o(rx_close_idx_o), .rx_close_len_o(rx_close_len_o), .rxbd_ptr_o(rxbd_ptr_o)
  );

  function automatic int wrap_inc(input int v, input int n);
    return (v == n - 1) ? 0 : v + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // leaves the bench one negedge later, with the flag visible
  task automatic issue(input logic [3:0] op, input logic [3:0] ch);
    cmd_wr_i = 1'b1; cmd_op_i = op; cmd_ch_i = ch;
    tick();
    cmd_wr_i = 1'b0;
  endtask

  task automatic rx_byte();
    rx_byte_i = 1'b1;
    tick();
    rx_byte_i = 1'b0;
  endtask

  task automatic run_frame();
    txbd_rdy_i[exp_tp] = 1'b1;
    tick();
    chk("R8 start", int'(tx_start_o), 1);
    txbd_rdy_i[exp_tp] = 1'b0;
    tx_frame_end_i = 1'b1;
    tick();
    tx_frame_end_i = 1'b0;
    exp_tp = wrap_inc(exp_tp, TX_BDS);
    chk("R9 ptr", int'(txbd_ptr_o), exp_tp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) tick();
    // R13
    chk("R13 flg", int'(cmd_flg_o), 0);
    chk("R13 txptr", int'(txbd_ptr_o), 0);
    chk("R13 rxptr", int'(rxbd_ptr_o), 0);
    chk("R13 run", int'(tx_run_o), 0);
    rst_ni = 1'b1;
    tick();

    // R3 unimplemented opcode
    issue(4'h9, CH);
    chk("R1 flg set", int'(cmd_flg_o), 1);
    tick();
    chk("R2 flg clear", int'(cmd_flg_o), 0);
    chk("R3 run", int'(tx_run_o), 0);
    chk("R3 stopped", int'(tx_stopped_o), 0);
    chk("R3 ptrs", int'(txbd_ptr_o) + int'(rxbd_ptr_o), 0);

    // R1 write while busy is dropped
    issue(4'h9, CH);
    issue(RESUME, CH);
    chk("R1 flg", int'(cmd_flg_o), 0);
    tick();
    chk("R1 ignored", int'(tx_run_o), 0);

    // R3 wrong channel
    issue(RESUME, CH ^ 4'h1);
    tick();
    chk("R3 channel", int'(tx_run_o), 0);

    // R7/R8 restart with descriptor not ready
    issue(RESUME, CH);
    tick();
    chk("R7 run", int'(tx_run_o), 1);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8 wait", int'(tx_start_o), 0);
    end
    txbd_rdy_i[0] = 1'b1;
    tick();
    chk("R8 start late", int'(tx_start_o), 1);
    chk("R7 ptr", int'(txbd_ptr_o), 0);
    txbd_rdy_i[0] = 1'b0;
    txbd_rdy_i[1] = 1'b1;
    tx_frame_end_i = 1'b1;
    tick();
    tx_frame_end_i = 1'b0;
    chk("R9 advance", int'(txbd_ptr_o), 1);
    tick();
    chk("R8 next start", int'(tx_start_o), 1);
    txbd_rdy_i[1] = 1'b0;

    // R5 graceful stop mid-frame with next descriptor ready
    txbd_rdy_i[2] = 1'b1;
    issue(GRACE, CH);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 flg held", int'(cmd_flg_o), 1);
      chk("R5 run held", int'(tx_run_o), 1);
    end
    tx_frame_end_i = 1'b1;
    tick();
    tx_frame_end_i = 1'b0;
    chk("R5 flg", int'(cmd_flg_o), 0);
    chk("R5 run", int'(tx_run_o), 0);
    chk("R5 stopped", int'(tx_stopped_o), 1);
    chk("R5 ptr", int'(txbd_ptr_o), 2);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 no start", int'(tx_start_o) + int'(tx_stopped_o), 0);
    end

    // R7 restart at the current descriptor
    issue(RESUME, CH);
    tick();
    tick();
    chk("R7 start", int'(tx_start_o), 1);
    chk("R7 ptr kept", int'(txbd_ptr_o), 2);
    txbd_rdy_i[2] = 1'b0;

    // R4 stop now during a frame
    issue(HALT, CH);
    tick();
    chk("R4 run", int'(tx_run_o), 0);
    chk("R4 stopped", int'(tx_stopped_o), 1);
    tx_frame_end_i = 1'b1;
    tick();
    tx_frame_end_i = 1'b0;
    chk("R4 stopped pulse", int'(tx_stopped_o), 0);
    chk("R4 ptr", int'(txbd_ptr_o), 2);

    // R6 graceful stop while idle and running
    issue(RESUME, CH);
    tick();
    chk("R6 pre run", int'(tx_run_o), 1);
    issue(GRACE, CH);
    tick();
    chk("R6 flg", int'(cmd_flg_o), 0);
    chk("R6 run", int'(tx_run_o), 0);
    chk("R6 stopped", int'(tx_stopped_o), 1);

    // R9 wrap of the transmit ring
    issue(RESUME, CH);
    tick();
    exp_tp = 2;
    for (int i = 0; i < 6; i++) run_frame();
    chk("R9 wrap", int'(txbd_ptr_o), 0);

    // R10 forced close of a partial buffer
    rxbd_rdy_i = '1;
    repeat (5) rx_byte();
    issue(CLOSE, CH);
    tick();
    chk("R10 close", int'(rx_close_o), 1);
    chk("R10 idx", int'(rx_close_idx_o), 0);
    chk("R10 len", int'(rx_close_len_o), 5);
    chk("R10 ptr", int'(rxbd_ptr_o), 1);

    // R11 full buffer closes by itself
    for (int i = 0; i < BUF_BYTES; i++) begin
      rx_byte();
      if (i < BUF_BYTES - 1) chk("R11 not yet", int'(rx_close_o), 0);
    end
    chk("R11 full close", int'(rx_close_o), 1);
    chk("R11 full len", int'(rx_close_len_o), BUF_BYTES);
    chk("R11 full idx", int'(rx_close_idx_o), 1);

    // R10 byte in the same cycle as close
    repeat (3) rx_byte();
    issue(CLOSE, CH);
    rx_byte_i = 1'b1;
    tick();
    rx_byte_i = 1'b0;
    chk("R10 same-cycle len", int'(rx_close_len_o), 4);
    chk("R10 same-cycle idx", int'(rx_close_idx_o), 2);

    // R12 wrap of the receive ring
    issue(CLOSE, CH);
    tick();
    chk("R12 len", int'(rx_close_len_o), 0);
    chk("R12 wrap", int'(rxbd_ptr_o), 0);

    // R11 descriptor not ready
    rxbd_rdy_i[0] = 1'b0;
    repeat (3) rx_byte();
    issue(CLOSE, CH);
    tick();
    chk("R11 no close", int'(rx_close_o), 0);
    chk("R11 ptr kept", int'(rxbd_ptr_o), 0);
    rxbd_rdy_i[0] = 1'b1;
    issue(CLOSE, CH);
    tick();
    chk("R11 dropped bytes", int'(rx_close_len_o), 0);

    // random receive closes with stray commands
    exp_rp = 1;
    for (int it = 0; it < 40; it++) begin
      int n;
      n = $urandom_range(0, BUF_BYTES - 1);
      for (int b = 0; b < n; b++) begin
        rx_byte();
        repeat ($urandom_range(0, 2)) tick();
        if ($urandom_range(0, 9) == 0) begin
          issue(4'($urandom_range(5, 15)), CH);
          tick();
        end
      end
      issue(CLOSE, CH);
      tick();
      chk("R10 rand close", int'(rx_close_o), 1);
      chk("R10 rand len", int'(rx_close_len_o), n);
      chk("R12 rand idx", int'(rx_close_idx_o), exp_rp);
      exp_rp = wrap_inc(exp_rp, RX_BDS);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule